// File: doc/BRIEF.md
# Dual-Diagonal Quasi-Cyclic LDPC Systematic Encoder

This block turns a message of `KB` sub-blocks, each `Z` bits wide, into a systematic codeword of a quasi-cyclic LDPC code. The parity part of the code's base matrix is dual-diagonal. The message part is a compile-time constant table held in the package. A `start` pulse opens the input. The message then arrives one sub-block per valid/ready beat. After a fixed computation time, the codeword leaves one sub-block per beat on a valid/ready output. The message sub-blocks come out first and unchanged, followed by the `MB` parity sub-blocks.

The encoder does not solve for the leading parity sub-block before the others. It assumes that sub-block is zero and predicts every other parity sub-block from that guess. Two independent engines build the predictions: one walks down from the top block row and one walks up from the bottom block row, both in the same cycles. Each engine rotates and accumulates the message sub-blocks of one block row, skipping zero blocks. When both engines finish, a single cycle forms the true leading parity sub-block, rotates it into one correction vector, and XORs that vector into every prediction.

Top module: `ddenc_top`

## Requirements
- R1: A base-matrix entry of -1 stands for an all-zero Z×Z block. A value s ≥ 0 maps a sub-block v to the sub-block r with r[k] = v[(k+s) mod Z] for every bit k.
- R2: In the parity section, parity column 0 holds shift `DSHIFT` in block rows 0 and MB-1 and shift 0 in block row `XROW`. Parity column j (1 ≤ j ≤ MB-1) holds shift 0 in block rows j-1 and j. Every other entry in the parity section is -1.
- R3: Every emitted codeword c satisfies H·cᵀ = 0 over GF(2), where H is the code built from the package table under R1 and R2.
- R4: The output sends KB+MB sub-blocks, one per accepted beat. Beats 0..KB-1 are the message sub-blocks in arrival order. Beat KB+i is parity sub-block p_i.
- R5: A `start` pulse while idle raises `in_ready` in the next cycle. Exactly KB input beats are then accepted, and `in_ready` is low in the cycle after the last of them.
- R6: A `start` pulse while the block is computing or sending has no effect: `in_ready` stays low and the sequence in progress finishes unchanged.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value in the next cycle.
- R8: Let F be the sum over block rows 0..XROW-1, and B the sum over block rows XROW..MB-1, of max(1, nonzero message blocks in the row). `out_valid` is low for the first max(F,B)+1 rising edges after the edge that accepts the last message beat, and high after the next edge.
- R9: After the last output beat is accepted, `out_valid` and `in_ready` are both low until the next `start` pulse.
- R10: While reset is held, and in the cycle after reset is released, `in_ready` and `out_valid` are low.
- R11: The all-zero message produces all-zero parity sub-blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a new codeword when idle |
| in_valid | input | 1 | Message sub-block present |
| in_ready | output | 1 | Block accepts a message sub-block |
| in_data | input | Z | Message sub-block |
| out_valid | output | 1 | Codeword sub-block present |
| out_ready | input | 1 | Receiver accepts a codeword sub-block |
| out_data | output | Z | Codeword sub-block |

## Verification
The bench uses the package defaults: Z=4, KB=4, MB=4, XROW=2 and DSHIFT=1. Block row 2 has no nonzero message entries, so the empty-row step of the upward engine is exercised. The downward chain (F=5) is one step longer than the upward chain (B=4), so the longer chain sets the latency. With only 16 message bits, every single-bit message can be tried alongside random and all-zero messages. Together these expose each column of the message section to the syndrome check.

// File: rtl/ddenc_pkg.sv
package ddenc_pkg;

    localparam int Z      = 4;
    localparam int KB     = 4;
    localparam int MB     = 4;
    localparam int XROW   = 2;
    localparam int DSHIFT = 1;

    localparam int NB = KB + MB;
    localparam int CW = $clog2(KB + 1);
    localparam int RW = (MB > 1) ? $clog2(MB) : 1;
    localparam int OW = $clog2(NB);

    // Message section of the base matrix: -1 = zero block, else shift value.
    localparam int BASE [MB][KB] = '{
        '{ 1, -1,  3,  0},
        '{-1,  2, -1,  1},
        '{-1, -1, -1, -1},
        '{ 2,  0, -1,  3}
    };

    typedef logic [Z-1:0] blk_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CALC,
        ST_FIX,
        ST_SEND
    } state_e;

    typedef struct packed {
        logic          vld;
        logic [RW-1:0] row;
        blk_t          lam;
    } lam_t;

    // r[k] = v[(k+s) mod Z]
    function automatic blk_t rot(blk_t v, int s);
        logic [2*Z-1:0] dbl;
        dbl = {v, v} >> (s % Z);
        return blk_t'(dbl);
    endfunction

    // First column >= from in the given row holding a nonzero block, else KB.
    function automatic int next_nz(int row, int from);
        int r;
        r = KB;
        for (int c = KB - 1; c >= 0; c--) begin
            if (c >= from && BASE[row][c] >= 0) r = c;
        end
        return r;
    endfunction

endpackage

// File: rtl/ddenc_lambda_eng.sv
module ddenc_lambda_eng
    import ddenc_pkg::*;
#(
    parameter int FIRST = 0,
    parameter int LAST  = 0,
    parameter int STEP  = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [KB-1:0][Z-1:0]  msg,
    output lam_t                  lam_o,
    output logic                  done
);

    logic          busy;
    logic [RW-1:0] row;
    logic [CW-1:0] col;
    blk_t          acc;
    blk_t          term;
    int            nxt;
    logic          row_end;
    logic [RW-1:0] row_nx;

    always_comb begin
        term = '0;
        for (int c = 0; c < KB; c++) begin
            if (int'(col) == c && BASE[row][c] >= 0) term = rot(msg[c], BASE[row][c]);
        end
        nxt     = next_nz(int'(row), int'(col) + 1);
        row_end = (nxt == KB);
        row_nx  = RW'(int'(row) + STEP);
        lam_o.vld = busy && row_end;
        lam_o.row = row;
        lam_o.lam = acc ^ term;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            row  <= '0;
            col  <= '0;
            acc  <= '0;
        end else if (go) begin
            busy <= 1'b1;
            done <= 1'b0;
            row  <= RW'(FIRST);
            col  <= CW'(next_nz(FIRST, 0));
            acc  <= '0;
        end else if (busy) begin
            if (row_end) begin
                acc <= '0;
                if (int'(row) == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    row <= row_nx;
                    col <= CW'(next_nz(int'(row_nx), 0));
                end
            end else begin
                acc <= acc ^ term;
                col <= CW'(nxt);
            end
        end
    end

endmodule

// File: rtl/ddenc_top.sv
module ddenc_top
    import ddenc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [Z-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [Z-1:0] out_data
);

    state_e               st;
    logic [OW-1:0]        cnt;
    logic [KB-1:0][Z-1:0] msg;
    blk_t                 par [MB];
    blk_t                 ptemp;
    blk_t                 p0;
    blk_t                 fix;
    logic                 in_fire;
    logic                 out_fire;
    logic                 go;
    lam_t                 fwd;
    lam_t                 bwd;
    logic                 fwd_done;
    logic                 bwd_done;

    assign in_ready  = (st == ST_LOAD);
    assign out_valid = (st == ST_SEND);
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;
    assign go        = in_fire && (cnt == OW'(KB - 1));
    assign p0        = par[XROW] ^ ptemp;
    assign fix       = rot(p0, DSHIFT);

    // Downward engine: rows 0..XROW-1, upward engine: rows MB-1..XROW.
    ddenc_lambda_eng #(.FIRST(0), .LAST(XROW - 1), .STEP(1)) u_fwd (
        .clk(clk), .rst(rst), .go(go), .msg(msg), .lam_o(fwd), .done(fwd_done)
    );

    ddenc_lambda_eng #(.FIRST(MB - 1), .LAST(XROW), .STEP(-1)) u_bwd (
        .clk(clk), .rst(rst), .go(go), .msg(msg), .lam_o(bwd), .done(bwd_done)
    );

    always_comb begin
        out_data = '0;
        for (int i = 0; i < KB; i++) begin
            if (cnt == OW'(i)) out_data = msg[i];
        end
        for (int i = 0; i < MB; i++) begin
            if (cnt == OW'(KB + i)) out_data = par[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
            msg <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    st  <= ST_LOAD;
                    cnt <= '0;
                end
                ST_LOAD: if (in_fire) begin
                    for (int k = 0; k < KB; k++) begin
                        if (cnt == OW'(k)) msg[k] <= in_data;
                    end
                    if (cnt == OW'(KB - 1)) begin
                        st  <= ST_CALC;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + OW'(1);
                    end
                end
                ST_CALC: if (fwd_done && bwd_done) st <= ST_FIX;
                ST_FIX: begin
                    st  <= ST_SEND;
                    cnt <= '0;
                end
                ST_SEND: if (out_fire) begin
                    if (cnt == OW'(NB - 1)) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + OW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Prediction chains (zero guess for p0) and the single correction step.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MB; i++) par[i] <= '0;
            ptemp <= '0;
        end else begin
            if (st == ST_FIX) begin
                par[0] <= p0;
                for (int i = 1; i < MB; i++) par[i] <= par[i] ^ fix;
            end
            for (int i = 1; i <= XROW; i++) begin
                if (fwd.vld && int'(fwd.row) + 1 == i)
                    par[i] <= fwd.lam ^ ((i == 1) ? '0 : par[i-1]);
            end
            if (bwd.vld && int'(bwd.row) == MB - 1)
                par[MB-1] <= bwd.lam;
            for (int i = XROW + 1; i < MB - 1; i++) begin
                if (bwd.vld && int'(bwd.row) == i)
                    par[i] <= bwd.lam ^ par[i+1];
            end
            if (bwd.vld && int'(bwd.row) == XROW)
                ptemp <= bwd.lam ^ par[XROW+1];
        end
    end

endmodule

// File: rtl/ddenc_chk.sv
module ddenc_chk
    import ddenc_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [Z-1:0]  out_data,
    input state_e        st,
    input logic [OW-1:0] cnt
);

    logic [OW-1:0] beats;

    always_ff @(posedge clk) begin
        if (rst) beats <= '0;
        else if (out_valid && out_ready)
            beats <= (beats == OW'(NB - 1)) ? '0 : beats + OW'(1);
    end

    p_open_input_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start) |=> in_ready);

    p_close_input_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && cnt == OW'(KB - 1)) |=> !in_ready);

    p_start_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CALC && start) |=> !in_ready);

    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_full_frame_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> (beats == '0));

endmodule

bind ddenc_top ddenc_chk u_chk (.*);

// File: tb/ddenc_top_test.sv
module ddenc_top_test;
    import ddenc_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [Z-1:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [Z-1:0] out_data;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 0;
    logic [Z-1:0] got [NB];
    logic [Z-1:0] m [KB];

    always #2 clk = ~clk;

    ddenc_top uut (
        .clk(clk), .rst(rst), .start(start),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Sub-block permutation per R1, written as a bit loop.
    function automatic logic [Z-1:0] bperm(logic [Z-1:0] v, int s);
        logic [Z-1:0] r;
        for (int k = 0; k < Z; k++) r[k] = v[(k + s) % Z];
        return r;
    endfunction

    // Full H entry per R2.
    function automatic int hval(int r, int c);
        int j;
        if (c < KB) return BASE[r][c];
        j = c - KB;
        if (j == 0) begin
            if (r == 0 || r == MB - 1) return DSHIFT;
            if (r == XROW) return 0;
            return -1;
        end
        if (r == j - 1 || r == j) return 0;
        return -1;
    endfunction

    function automatic int latency();
        int f, b, n;
        f = 0; b = 0;
        for (int r = 0; r < MB; r++) begin
            n = 0;
            for (int c = 0; c < KB; c++) if (BASE[r][c] >= 0) n++;
            if (n < 1) n = 1;
            if (r < XROW) f += n; else b += n;
        end
        return ((f > b) ? f : b) + 2;
    endfunction

    task automatic run_word(input int gap, input int bp, input bit zero_msg);
        int lat, n, cyc;
        bit bad_lat, bad_busy, bad_hold;
        logic [Z-1:0] held;
        bit waiting;
        logic [Z-1:0] syn;
        lat = latency();
        @(negedge clk);
        chk(!in_ready && !out_valid, "R9", "idle before start", int'(in_ready), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(in_ready, "R5", "in_ready after start", int'(in_ready), 1);
        for (int k = 0; k < KB; k++) begin
            if (gap != 0 && k == 1) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = m[k];
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(!in_ready, "R5", "in_ready low after last beat", int'(in_ready), 0);
        bad_lat = 0; bad_busy = 0;
        for (int i = 0; i < lat; i++) begin
            if (out_valid) bad_lat = 1;
            if (i >= 2 && in_ready) bad_busy = 1;
            start = (i == 1);
            @(negedge clk);
        end
        start = 1'b0;
        chk(!bad_lat && out_valid, "R8", "out_valid timing", int'(out_valid), 1);
        chk(!bad_busy, "R6", "start during compute ignored", int'(bad_busy), 0);
        n = 0; cyc = 0; bad_hold = 0; bad_busy = 0; waiting = 0; held = '0;
        while (n < NB && cyc < 100) begin
            if (!out_valid) bad_hold = 1;
            if (waiting && out_data !== held) bad_hold = 1;
            if (in_ready) bad_busy = 1;
            out_ready = (bp != 0) ? (cyc % 3 != 0) : 1'b1;
            start = (cyc == 2);
            if (out_ready) begin
                got[n] = out_data;
                n++;
                waiting = 0;
            end else begin
                held = out_data;
                waiting = 1;
            end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        start = 1'b0;
        chk(!bad_hold, "R7", "valid/data held under backpressure", int'(bad_hold), 0);
        chk(!bad_busy, "R6", "start during send ignored", int'(bad_busy), 0);
        chk(!out_valid && !in_ready, "R9", "idle after last beat", int'(out_valid), 0);
        for (int k = 0; k < KB; k++)
            chk(got[k] === m[k], "R4", "systematic sub-block", int'(got[k]), int'(m[k]));
        for (int r = 0; r < MB; r++) begin
            syn = '0;
            for (int c = 0; c < NB; c++)
                if (hval(r, c) >= 0) syn ^= bperm(got[c], hval(r, c));
            // H built per R1 and R2
            chk(syn === '0, "R3", "syndrome row (R1 R2)", int'(syn), 0);
        end
        if (zero_msg)
            for (int i = 0; i < MB; i++)
                chk(got[KB+i] === '0, "R11", "zero parity", int'(got[KB+i]), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!in_ready && !out_valid, "R10", "outputs during reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!in_ready && !out_valid, "R10", "outputs after reset", int'(in_ready), 0);
        start = 1'b0;
        for (int k = 0; k < KB; k++) m[k] = '0;
        run_word(0, 0, 1'b1);
        for (int b = 0; b < KB * Z; b++) begin
            for (int k = 0; k < KB; k++) m[k] = '0;
            m[b / Z][b % Z] = 1'b1;
            run_word(b % 2, (b / 2) % 2, 1'b0);
        end
        for (int t = 0; t < 12; t++) begin
            for (int k = 0; k < KB; k++) m[k] = Z'($urandom);
            run_word(t % 2, 1 - (t % 2), 1'b0);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule